// File: doc/BRIEF.md
# LPC Host I/O Cycle Engine

This block is the host side of a 4-bit multiplexed LPC bus, limited to I/O read and I/O write cycles. A user-side request port supplies the direction, a 16-bit I/O address and a write byte. The engine then runs the whole bus cycle and returns done, or error, together with the read byte. The bus is framed by an active-low frame strobe. The shared nibble lane is driven through separate output, output-enable and input signals, so the tristate buffer sits outside the block.

A cycle runs through these phases in order: a one-clock preamble with the stop code, START, cycle type, four address nibbles, host turnaround, sync, two data nibbles and the peripheral turnaround. START can be stretched to two clocks on request. The host gives up the bus and waits for a ready sync code from the peripheral. While waiting it can abandon the cycle by pulling the frame strobe low again, which it does in three cases: the user asks for it, the wait runs too long, or the sync code is not understood.

Top module: `lpc_io_host`

## Requirements
- R1: While idle (busy low), lframe_n is high and lad_oe is low.
- R2: A request is taken only on a clock where req_start is high and busy is low. req_write, req_extend, req_addr and req_wdata are captured in that clock, so changing them later, or raising req_start while busy, has no effect on the cycle or the bus.
- R3: The clock after acceptance drives lad_out = 4'hF with lframe_n high and lad_oe high. After that come one clock, or two clocks when req_extend was captured high, of lframe_n low with lad_out = 4'h0.
- R4: In the clock after START, lframe_n is high and the driven nibble is 4'h2 for a write (req_write = 1) and 4'h0 for a read.
- R5: The next four clocks drive the address nibbles, bits 15:12 first and bits 3:0 last.
- R6: The host turnaround drives 4'hF for one clock, then holds lad_oe low for one clock.
- R7: In each sync clock lad_oe is low and lad_in is sampled. 4'h5 means wait and 4'h0 means ready, and data begins the clock after ready. Ready must arrive within SYNC_LIMIT sync clocks. A wait code in the SYNC_LIMIT-th sync clock aborts the cycle with error.
- R8: Data moves as the low nibble (bits 3:0) and then the high nibble (bits 7:4). A write drives them with lad_oe high. A read samples lad_in and presents the byte on rd_data.
- R9: After data come two clocks with lad_oe low and lframe_n high. In the next clock busy is low and done is high for exactly one clock, with rd_data valid.
- R10: A req_abort pulse seen before data starts makes the engine leave sync by holding lframe_n low with lad_out = 4'hF and lad_oe high for exactly ABORT_CLKS clocks. It then returns to idle with a one-clock error pulse, no done and no data phase.
- R11: A req_abort during the data phase has no effect: the data nibbles, turnaround and done pulse proceed normally.
- R12: A sync code other than 4'h5 or 4'h0 triggers the R10 abort sequence and the error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Request strobe, taken while busy is low |
| req_write | input | 1 | 1 = I/O write, 0 = I/O read |
| req_extend | input | 1 | 1 = two-clock START |
| req_addr | input | 16 | I/O address |
| req_wdata | input | 8 | Write byte |
| req_abort | input | 1 | Abort request, honoured before data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock pulse on successful completion |
| error | output | 1 | One-clock pulse on abort, timeout or bad sync |
| rd_data | output | 8 | Read byte, valid with done |
| lframe_n | output | 1 | Active-low frame strobe |
| lad_out | output | 4 | Nibble to drive onto the bus |
| lad_oe | output | 1 | Output enable for lad_out |
| lad_in | input | 4 | Nibble sampled from the bus |

## Verification
The bench builds the engine with SYNC_LIMIT = 6 and ABORT_CLKS = 5. These short values put both edges of the sync window in reach: five wait codes followed by ready must complete, and six wait codes must abort. They also make the abort length clearly different from the four-clock minimum. A peripheral model inside the driver answers with chosen wait counts, illegal codes and read bytes, and raises aborts both before and during data.

// File: rtl/lpc_io_host_pkg.sv
// Shared bus codes and phase encoding for the LPC host I/O engine.
package lpc_io_host_pkg;
    localparam logic [3:0] NIB_STOP  = 4'hF;
    localparam logic [3:0] NIB_START = 4'h0;
    localparam logic [3:0] NIB_IOWR  = 4'h2;
    localparam logic [3:0] NIB_IORD  = 4'h0;
    localparam logic [3:0] NIB_WAIT  = 4'h5;
    localparam logic [3:0] NIB_READY = 4'h0;

    typedef enum logic [3:0] {
        PH_IDLE, PH_PRE, PH_START, PH_START2, PH_CTYPE, PH_ADDR,
        PH_HTAR1, PH_HTAR2, PH_SYNC, PH_DATA, PH_PTAR1, PH_PTAR2, PH_ABORT
    } phase_t;

    typedef enum logic [1:0] {SK_WAIT, SK_READY, SK_BAD} sync_kind_t;
endpackage

// File: rtl/lpc_host_req.sv
// Request capture and nibble selection.
// Assumes: ADDR_W and DATA_W are multiples of 4. Fields are loaded once per cycle;
// the address is served most significant nibble first, data least significant first.
module lpc_host_req #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic              in_extend,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic [IDX_W-1:0]  nib_idx,
    output logic              is_write,
    output logic              extend,
    output logic [3:0]        addr_nib,
    output logic [3:0]        data_nib
);
    localparam int ANIB = ADDR_W / 4;
    localparam int DNIB = DATA_W / 4;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [3:0]        anibs [ANIB];
    logic [3:0]        dnibs [DNIB];

    // Latch the request fields at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            is_write <= 1'b0;
            extend   <= 1'b0;
        end else if (load) begin
            addr_q   <= in_addr;
            wdata_q  <= in_wdata;
            is_write <= in_write;
            extend   <= in_extend;
        end
    end

    for (genvar g = 0; g < ANIB; g++) begin : g_anib
        assign anibs[g] = addr_q[4*g +: 4];
    end
    for (genvar g = 0; g < DNIB; g++) begin : g_dnib
        assign dnibs[g] = wdata_q[4*g +: 4];
    end

    // Pick the address nibble, top nibble at index 0.
    always_comb begin
        addr_nib = 4'h0;
        for (int i = 0; i < ANIB; i++)
            if (nib_idx == IDX_W'(ANIB - 1 - i)) addr_nib = anibs[i];
    end

    // Pick the data nibble, bottom nibble at index 0.
    always_comb begin
        data_nib = 4'h0;
        for (int i = 0; i < DNIB; i++)
            if (nib_idx == IDX_W'(i)) data_nib = dnibs[i];
    end
endmodule

// File: rtl/lpc_host_sync.sv
// Sync code classifier and wait-window counter.
// Assumes: active is high for exactly the clocks in which the sync nibble is sampled.
module lpc_host_sync
    import lpc_io_host_pkg::*;
#(
    parameter int SYNC_LIMIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic [3:0] code,
    output sync_kind_t kind,
    output logic       expired
);
    localparam int CW = $clog2(SYNC_LIMIT + 1);

    logic [CW-1:0] wait_cnt;

    // Classify the sampled nibble.
    always_comb begin
        if (code == NIB_WAIT)       kind = SK_WAIT;
        else if (code == NIB_READY) kind = SK_READY;
        else                        kind = SK_BAD;
    end

    // Count wait codes seen in the current sync phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)   wait_cnt <= '0;
        else if (kind == SK_WAIT) wait_cnt <= wait_cnt + 1'b1;
    end

    assign expired = active && (kind == SK_WAIT) && (wait_cnt == CW'(SYNC_LIMIT - 1));
endmodule

// File: rtl/lpc_host_count.sv
// Run-length counter: last is high on the LIMIT-th consecutive clock of run.
// Assumes: LIMIT >= 1; clearing happens whenever run is low.
module lpc_host_count #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Advance while running, restart otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign last = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/lpc_io_host.sv
// LPC host I/O cycle engine: sequences one I/O read or write per request.
// Assumes: lad_in reflects the external bus (pulled up when undriven); outputs
// are decoded from the registered phase, so each phase lasts whole clocks.
module lpc_io_host
    import lpc_io_host_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int SYNC_LIMIT = 16,
    parameter int ABORT_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_write,
    input  logic              req_extend,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_abort,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [DATA_W-1:0] rd_data,
    output logic              lframe_n,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        lad_in
);
    localparam int ANIB  = ADDR_W / 4;
    localparam int DNIB  = DATA_W / 4;
    localparam int NMAX  = (ANIB > DNIB) ? ANIB : DNIB;
    localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1;

    phase_t            phase, phase_nx;
    logic [IDX_W-1:0]  nib_cnt, nib_cnt_nx;
    logic              abort_pend;
    logic              accept, pre_data;
    logic              is_write, extend;
    logic [3:0]        addr_nib, data_nib;
    sync_kind_t        skind;
    logic              sync_expired, abort_last;

    assign accept   = (phase == PH_IDLE) && req_start;
    assign busy     = (phase != PH_IDLE);
    assign pre_data = phase inside {PH_PRE, PH_START, PH_START2, PH_CTYPE,
                                    PH_ADDR, PH_HTAR1, PH_HTAR2, PH_SYNC};

    lpc_host_req #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_req (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .in_write(req_write), .in_extend(req_extend),
        .in_addr(req_addr), .in_wdata(req_wdata), .nib_idx(nib_cnt),
        .is_write(is_write), .extend(extend),
        .addr_nib(addr_nib), .data_nib(data_nib)
    );

    lpc_host_sync #(.SYNC_LIMIT(SYNC_LIMIT)) u_sync (
        .clk(clk), .rst_n(rst_n), .active(phase == PH_SYNC),
        .code(lad_in), .kind(skind), .expired(sync_expired)
    );

    lpc_host_count #(.LIMIT(ABORT_CLKS)) u_abort_len (
        .clk(clk), .rst_n(rst_n), .run(phase == PH_ABORT), .last(abort_last)
    );

    // Phase sequencing and nibble index.
    always_comb begin
        phase_nx   = phase;
        nib_cnt_nx = nib_cnt;
        case (phase)
            PH_IDLE:   if (accept) phase_nx = PH_PRE;
            PH_PRE:    phase_nx = PH_START;
            PH_START:  phase_nx = extend ? PH_START2 : PH_CTYPE;
            PH_START2: phase_nx = PH_CTYPE;
            PH_CTYPE: begin
                phase_nx   = PH_ADDR;
                nib_cnt_nx = '0;
            end
            PH_ADDR: begin
                if (nib_cnt == IDX_W'(ANIB - 1)) phase_nx = PH_HTAR1;
                else nib_cnt_nx = nib_cnt + 1'b1;
            end
            PH_HTAR1:  phase_nx = PH_HTAR2;
            PH_HTAR2:  phase_nx = PH_SYNC;
            PH_SYNC: begin
                if (abort_pend || skind == SK_BAD || sync_expired) begin
                    phase_nx = PH_ABORT;
                end else if (skind == SK_READY) begin
                    phase_nx   = PH_DATA;
                    nib_cnt_nx = '0;
                end
            end
            PH_DATA: begin
                if (nib_cnt == IDX_W'(DNIB - 1)) phase_nx = PH_PTAR1;
                else nib_cnt_nx = nib_cnt + 1'b1;
            end
            PH_PTAR1:  phase_nx = PH_PTAR2;
            PH_PTAR2:  phase_nx = PH_IDLE;
            PH_ABORT:  if (abort_last) phase_nx = PH_IDLE;
            default:   phase_nx = PH_IDLE;
        endcase
    end

    // State, abort latch and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            nib_cnt    <= '0;
            abort_pend <= 1'b0;
            done       <= 1'b0;
            error      <= 1'b0;
        end else begin
            phase      <= phase_nx;
            nib_cnt    <= nib_cnt_nx;
            abort_pend <= pre_data && (abort_pend || req_abort);
            done       <= (phase == PH_PTAR2);
            error      <= (phase == PH_ABORT) && abort_last;
        end
    end

    // Collect read nibbles, low nibble first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (phase == PH_DATA && !is_write) begin
            for (int i = 0; i < DNIB; i++)
                if (nib_cnt == IDX_W'(i)) rd_data[4*i +: 4] <= lad_in;
        end
    end

    // Bus drive decode from the current phase.
    always_comb begin
        lframe_n = !(phase inside {PH_START, PH_START2, PH_ABORT});
        lad_oe   = 1'b0;
        lad_out  = NIB_STOP;
        case (phase)
            PH_PRE, PH_HTAR1, PH_ABORT: lad_oe = 1'b1;
            PH_START, PH_START2: begin
                lad_oe  = 1'b1;
                lad_out = NIB_START;
            end
            PH_CTYPE: begin
                lad_oe  = 1'b1;
                lad_out = is_write ? NIB_IOWR : NIB_IORD;
            end
            PH_ADDR: begin
                lad_oe  = 1'b1;
                lad_out = addr_nib;
            end
            PH_DATA: begin
                lad_oe  = is_write;
                lad_out = is_write ? data_nib : NIB_STOP;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpc_io_host_chk.sv
// Protocol checker for lpc_io_host, attached through bind.
// Assumes: sampled on the rising clock edge, disabled during reset.
module lpc_io_host_chk #(
    parameter int ABORT_CLKS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_start,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       lframe_n,
    input logic       lad_oe,
    input logic [3:0] lad_out
);
    logic [7:0] low_stop_cnt;

    // Length of the current run of frame-low clocks carrying the stop code.
    always_ff @(posedge clk) begin
        if (!rst_n)                            low_stop_cnt <= '0;
        else if (!lframe_n && lad_out == 4'hF) low_stop_cnt <= low_stop_cnt + 1'b1;
        else                                   low_stop_cnt <= '0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lframe_n && !lad_oe)); // R1
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy) |=> busy); // R2
    AST_START_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lframe_n) && lad_out == 4'h0) |-> $past(lframe_n && lad_oe && lad_out == 4'hF)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R10
    AST_ABORT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lframe_n) && low_stop_cnt != 0) |-> (low_stop_cnt == 8'(ABORT_CLKS))); // R10
    AST_ERR_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(!lframe_n)); // R10
endmodule

bind lpc_io_host lpc_io_host_chk #(.ABORT_CLKS(ABORT_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .busy(busy),
    .done(done), .error(error), .lframe_n(lframe_n),
    .lad_oe(lad_oe), .lad_out(lad_out)
);

// File: tb/lpc_io_host_test.sv
// Scoreboard bench: the driver plays both user and peripheral, pushing the
// expected outcome of each cycle; the monitor pops it on done or error.
module lpc_io_host_test;
    localparam int SYNC_LIM = 6;
    localparam int ABT      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0, req_write = 1'b0, req_extend = 1'b0, req_abort = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, error, lframe_n, lad_oe;
    logic [7:0]  rd_data;
    logic [3:0]  lad_out;
    logic [3:0]  lad_in = 4'hF;

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic       err;
        logic       is_rd;
        logic [7:0] rd;
    } exp_t;
    exp_t exp_q[$];
    exp_t got;

    always #4 clk = ~clk;

    lpc_io_host #(.SYNC_LIMIT(SYNC_LIM), .ABORT_CLKS(ABT)) uut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_extend(req_extend), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_abort(req_abort), .busy(busy), .done(done), .error(error),
        .rd_data(rd_data), .lframe_n(lframe_n), .lad_out(lad_out),
        .lad_oe(lad_oe), .lad_in(lad_in)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Monitor: compare every completion pulse with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && (done || error)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected completion", {14'h0, done, error}, 16'h0);
            end else begin
                got = exp_q.pop_front();
                check(error == got.err, got.err ? "R10 error pulse" : "R9 done pulse",
                      {15'h0, error}, {15'h0, got.err});
                check(done == !got.err, "R9 done vs error", {15'h0, done}, {15'h0, !got.err});
                if (got.is_rd && !got.err)
                    check(rd_data == got.rd, "R8 read byte", {8'h0, rd_data}, {8'h0, got.rd});
            end
        end
    end

    // mode: 0 normal, 1 illegal sync code, 2 abort before data, 3 abort during data
    task automatic run_cycle(input bit w, input logic [15:0] a, input logic [7:0] d,
                             input bit ext, input int waits, input int mode, input bit poke);
        bit    exp_err;
        bit    aborted;
        bit    ready;
        int    k;
        int    n;
        logic [3:0] code;
        string abort_tag;
        exp_err   = (mode == 1) || (mode == 2) || (waits >= SYNC_LIM);
        abort_tag = (mode == 1) ? "R12 abort length" : (mode == 2) ? "R10 abort length" : "R7 timeout abort length";
        exp_q.push_back('{err: exp_err, is_rd: !w, rd: d});
        @(negedge clk);
        req_start = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_extend = ext;
        @(negedge clk);
        req_start = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~w; req_extend = ~ext; // R2 late changes
        check(lframe_n && lad_oe && lad_out == 4'hF, "R3 preamble", {11'h0, lframe_n, lad_out}, 16'h1F);
        @(negedge clk);
        check(!lframe_n && lad_oe && lad_out == 4'h0, "R3 start", {11'h0, lframe_n, lad_out}, 16'h00);
        if (ext) begin
            @(negedge clk);
            check(!lframe_n && lad_oe && lad_out == 4'h0, "R3 extended start", {11'h0, lframe_n, lad_out}, 16'h00);
        end
        @(negedge clk);
        check(lframe_n && lad_oe && lad_out == (w ? 4'h2 : 4'h0), "R4 cycle type",
              {11'h0, lframe_n, lad_out}, {11'h0, 1'b1, (w ? 4'h2 : 4'h0)});
        if (poke) req_start = 1'b1; // R2 request while busy
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req_start = 1'b0;
            check(lad_oe && lad_out == a[15-4*i -: 4], "R5 address nibble",
                  {12'h0, lad_out}, {12'h0, a[15-4*i -: 4]});
        end
        @(negedge clk);
        check(lad_oe && lad_out == 4'hF, "R6 turnaround drive", {11'h0, lad_oe, lad_out}, 16'h1F);
        @(negedge clk);
        check(!lad_oe, "R6 turnaround release", {15'h0, lad_oe}, 16'h0);
        if (mode == 2) req_abort = 1'b1;
        @(negedge clk);
        req_abort = 1'b0;
        aborted = 1'b0; ready = 1'b0; k = 0;
        while (!aborted && !ready && k < 64) begin
            check(lframe_n && !lad_oe, "R7 sync bus released", {14'h0, lframe_n, lad_oe}, 16'h2);
            code = (mode == 1) ? 4'h9 : ((k < waits) ? 4'h5 : 4'h0);
            lad_in = code;
            @(negedge clk);
            if (!lframe_n) aborted = 1'b1;
            else if (code == 4'h0) ready = 1'b1;
            k++;
        end
        lad_in = 4'hF;
        check(aborted == exp_err, "R7 sync outcome", {15'h0, aborted}, {15'h0, exp_err});
        if (aborted) begin
            n = 0;
            while (!lframe_n && n < 64) begin
                if (!(lad_oe && lad_out == 4'hF)) check(1'b0, abort_tag, {12'h0, lad_out}, 16'hF);
                n++;
                @(negedge clk);
            end
            check(n == ABT, abort_tag, 16'(n), 16'(ABT));
            check(!busy && !lad_oe, "R1 idle after abort", {14'h0, busy, lad_oe}, 16'h0);
        end else if (ready) begin
            for (int j = 0; j < 2; j++) begin
                if (mode == 3) req_abort = 1'b1; // R11
                if (w) check(lad_oe && lad_out == d[4*j +: 4], "R8 write nibble",
                             {11'h0, lad_oe, lad_out}, {11'h0, 1'b1, d[4*j +: 4]});
                else begin
                    lad_in = d[4*j +: 4];
                    check(!lad_oe, "R8 read bus released", {15'h0, lad_oe}, 16'h0);
                end
                check(lframe_n, "R11 frame high in data", {15'h0, lframe_n}, 16'h1);
                @(negedge clk);
            end
            req_abort = 1'b0;
            lad_in = 4'hF;
            check(!lad_oe && lframe_n, "R9 peripheral turnaround 1", {14'h0, lframe_n, lad_oe}, 16'h2);
            @(negedge clk);
            check(!lad_oe && lframe_n, "R9 peripheral turnaround 2", {14'h0, lframe_n, lad_oe}, 16'h2);
            @(negedge clk);
            check(!busy && done, "R9 idle with done", {14'h0, busy, done}, 16'h1);
        end
        if (poke) begin
            @(negedge clk);
            check(!busy && lframe_n && !lad_oe, "R2 busy request ignored",
                  {13'h0, busy, lframe_n, lad_oe}, 16'h2);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && lframe_n && !lad_oe, "R1 reset idle", {13'h0, busy, lframe_n, lad_oe}, 16'h2);
        check(!done && !error, "R9 no pulse at reset", {14'h0, done, error}, 16'h0);
        run_cycle(1'b1, 16'h1234, 8'hA5, 1'b0, 0, 0, 1'b1);
        run_cycle(1'b0, 16'hABCD, 8'h3C, 1'b0, 2, 0, 1'b0);
        run_cycle(1'b1, 16'hF00F, 8'h96, 1'b1, 1, 0, 1'b0);
        run_cycle(1'b0, 16'h5A5A, 8'hE1, 1'b1, SYNC_LIM - 1, 0, 1'b0); // R7 last legal wait
        run_cycle(1'b0, 16'h0001, 8'h77, 1'b0, SYNC_LIM, 0, 1'b0);     // R7 timeout
        run_cycle(1'b1, 16'h8000, 8'h44, 1'b0, 0, 1, 1'b0);            // R12
        run_cycle(1'b0, 16'h0F0F, 8'h12, 1'b0, 3, 2, 1'b0);            // R10
        run_cycle(1'b1, 16'h2468, 8'hC3, 1'b0, 1, 3, 1'b0);            // R11 write
        run_cycle(1'b0, 16'h1357, 8'h5E, 1'b1, 0, 3, 1'b0);            // R11 read
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all outcomes seen", 16'(exp_q.size()), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule